// File: doc/BRIEF.md
# Flash Block Write-Protect Manager

This block holds a write-protection state for every erase block of a NAND-style flash array. Each block is in one of three states: unlocked, locked, or lock-tight. Lock-tight can only be left by a reset. Software writes a first and a last block index through a small register bus. It then issues an opcode on a command strobe. The block walks the selected range one block per clock and applies the opcode's rule to each block.

While it walks, `busy` stays high. When the walk ends, `done` pulses. A protection-status register reports the state most recently written to a block. A block index past the end of the array stops the walk and raises `cmd_err`. The array's program and erase paths read these states elsewhere. This block only keeps and updates them.

Top module: `flash_wp_manager`

## Requirements
- R1: After reset, every block is locked, the status register (address 0x02) reads 0x0002, and `busy`, `done` and `cmd_err` are low.
- R2: Block states are one-hot: lock-tight = 3'b001, locked = 3'b010, unlocked = 3'b100. The state of block n reads back in bits [2:0] at address 0x80+n, with all other bits zero.
- R3: Opcode 0x23 sets every block from first to last (inclusive) that is not lock-tight to unlocked.
- R4: Opcode 0x2A sets every block in the range that is not lock-tight to locked.
- R5: Opcode 0x27 walks blocks 0 to NUM_BLOCKS-1, ignoring the range registers, and sets every block that is not lock-tight to unlocked.
- R6: Opcode 0x2C sets every locked or lock-tight block in the range to lock-tight. Unlocked blocks in the range are skipped.
- R7: A lock-tight block is unaffected by 0x23, 0x27 and 0x2A, and stays lock-tight until reset.
- R8: A write to address 0x00 stores the low clog2(NUM_BLOCKS) bits of the data into both the first-block register (reads at 0x00) and the last-block register (reads at 0x01). A write to 0x01 changes only the last-block register.
- R9: Each block the opcode acts on (that is, each block not skipped) writes its new state into bits [2:0] of the status register, with the upper bits zero. Skipped blocks leave the register unchanged.
- R10: A command accepted at one clock edge holds `busy` high for exactly (last-first+1) cycles, one block per cycle. `busy` falls together with a one-cycle `done` pulse.
- R11: If first > last, the command produces `done` in the cycle after acceptance. `busy` does not rise, no block changes, and `cmd_err` stays low.
- R12: When the walk reaches an index at or above NUM_BLOCKS, it stops there and `done` pulses with `cmd_err` high. Blocks before that index are already updated. `cmd_err` holds until the next accepted command, which clears it.
- R13: Any opcode other than 0x23, 0x27, 0x2A and 0x2C produces `done` in the cycle after acceptance, with `cmd_err` high and no block changed.
- R14: A command strobe while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 8 | Register read address (combinational read) |
| rd_data | output | 16 | Register read data |
| cmd_valid | input | 1 | Command strobe, accepted when not busy |
| cmd_op | input | 8 | Command opcode |
| busy | output | 1 | Range walk in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| cmd_err | output | 1 | Last command hit an out-of-range block or was unknown |

## Verification
A wrong stored state shows up as a wrong status value as soon as the next walk touches that block. Whether or not a walk touches it, the state is visible at once through its 0x80+n read window, so every test reads back the blocks on both sides of each range edge. A walker that is off by one shows up at `done`, one cycle early or late, and the per-command busy-cycle count catches it. A broken skip rule for lock-tight blocks appears after the very next command over them, as a changed readback.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [2:0] {
        PS_TIGHT    = 3'b001,
        PS_LOCKED   = 3'b010,
        PS_UNLOCKED = 3'b100
    } prot_e;

    typedef enum logic [7:0] {
        OP_UNLOCK     = 8'h23,
        OP_UNLOCK_ALL = 8'h27,
        OP_LOCK       = 8'h2A,
        OP_TIGHT      = 8'h2C
    } op_e;

    localparam logic [7:0] RA_FIRST  = 8'h00;
    localparam logic [7:0] RA_LAST   = 8'h01;
    localparam logic [7:0] RA_STATUS = 8'h02;

    typedef struct packed {
        logic  act;
        prot_e val;
    } upd_t;

    function automatic logic op_known(logic [7:0] op);
        return (op == OP_UNLOCK) || (op == OP_UNLOCK_ALL) ||
               (op == OP_LOCK)   || (op == OP_TIGHT);
    endfunction

    function automatic upd_t apply_op(logic [7:0] op, prot_e cur);
        upd_t u;
        u.act = 1'b0;
        u.val = cur;
        case (op)
            OP_UNLOCK, OP_UNLOCK_ALL: if (cur != PS_TIGHT) begin
                u.act = 1'b1;
                u.val = PS_UNLOCKED;
            end
            OP_LOCK: if (cur != PS_TIGHT) begin
                u.act = 1'b1;
                u.val = PS_LOCKED;
            end
            OP_TIGHT: if (cur != PS_UNLOCKED) begin
                u.act = 1'b1;
                u.val = PS_TIGHT;
            end
            default: ;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/wp_walker.sv
module wp_walker
    import wp_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int BW         = $clog2(NUM_BLOCKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [7:0]    op_in,
    input  logic [BW-1:0] first,
    input  logic [BW-1:0] last,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [BW-1:0] cur,
    output logic [7:0]    op_q,
    output logic          step
);
    localparam logic [BW:0]   NB    = (BW+1)'(NUM_BLOCKS);
    localparam logic [BW-1:0] LASTB = BW'(NUM_BLOCKS - 1);

    logic [BW-1:0] end_q;
    logic          out_of_range;

    assign out_of_range = ({1'b0, cur} >= NB);
    assign step         = busy && !out_of_range;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            err   <= 1'b0;
            cur   <= '0;
            end_q <= '0;
            op_q  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    err  <= 1'b0;
                    op_q <= op_in;
                    if (op_in == OP_UNLOCK_ALL) begin
                        cur   <= '0;
                        end_q <= LASTB;
                        busy  <= 1'b1;
                    end else if (!op_known(op_in)) begin
                        err  <= 1'b1;
                        done <= 1'b1;
                    end else if (first > last) begin
                        done <= 1'b1;
                    end else begin
                        cur   <= first;
                        end_q <= last;
                        busy  <= 1'b1;
                    end
                end
            end else if (out_of_range) begin
                err  <= 1'b1;
                busy <= 1'b0;
                done <= 1'b1;
            end else if (cur == end_q) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                cur <= cur + 1'b1;
            end
        end
    end

    // R10
    busy_end_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R12
    err_rise_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);

endmodule

// File: rtl/wp_block_array.sv
module wp_block_array
    import wp_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int BW         = $clog2(NUM_BLOCKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [BW-1:0] idx,
    input  logic [7:0]    op,
    input  logic [BW-1:0] rd_idx,
    output logic [2:0]    rd_state,
    output logic          act,
    output prot_e         new_val
);
    localparam logic [BW:0] NB = (BW+1)'(NUM_BLOCKS);

    prot_e st_q [NUM_BLOCKS];
    prot_e sel;
    upd_t  upd;

    always_comb begin
        sel      = PS_LOCKED;
        rd_state = 3'b000;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (idx == BW'(i))    sel      = st_q[i];
            if (rd_idx == BW'(i)) rd_state = st_q[i];
        end
    end

    assign upd     = apply_op(op, sel);
    assign act     = step && upd.act;
    assign new_val = upd.val;

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
        always_ff @(posedge clk) begin
            if (rst)
                st_q[g] <= PS_LOCKED;
            else if (act && idx == BW'(g))
                st_q[g] <= new_val;
        end

        // R7
        tight_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (st_q[g] == PS_TIGHT) |=> (st_q[g] == PS_TIGHT));
    end

    // R12
    step_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> ({1'b0, idx} < NB));

endmodule

// File: rtl/flash_wp_manager.sv
module flash_wp_manager
    import wp_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    output logic              busy,
    output logic              done,
    output logic              cmd_err
);
    localparam int BW = $clog2(NUM_BLOCKS);
    localparam logic [DATA_W-1:0] STATUS_RST = DATA_W'(PS_LOCKED);

    logic [BW-1:0]     first_q, last_q;
    logic [DATA_W-1:0] status_q;
    logic              go, step, act;
    logic [BW-1:0]     cur;
    logic [7:0]        op_q;
    logic [2:0]        rd_state;
    prot_e             new_val;

    assign go = cmd_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q  <= '0;
            last_q   <= '0;
            status_q <= STATUS_RST;
        end else begin
            if (wr_en && wr_addr == ADDR_W'(RA_FIRST)) begin
                first_q <= wr_data[BW-1:0];
                last_q  <= wr_data[BW-1:0];
            end else if (wr_en && wr_addr == ADDR_W'(RA_LAST)) begin
                last_q <= wr_data[BW-1:0];
            end
            if (act)
                status_q <= DATA_W'(new_val);
        end
    end

    wp_walker #(.NUM_BLOCKS(NUM_BLOCKS), .BW(BW)) u_walker (
        .clk   (clk),
        .rst   (rst),
        .go    (go),
        .op_in (cmd_op),
        .first (first_q),
        .last  (last_q),
        .busy  (busy),
        .done  (done),
        .err   (cmd_err),
        .cur   (cur),
        .op_q  (op_q),
        .step  (step)
    );

    wp_block_array #(.NUM_BLOCKS(NUM_BLOCKS), .BW(BW)) u_array (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .idx      (cur),
        .op       (op_q),
        .rd_idx   (rd_addr[BW-1:0]),
        .rd_state (rd_state),
        .act      (act),
        .new_val  (new_val)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr[ADDR_W-1]) begin
            if (rd_addr[ADDR_W-2:BW] == '0)
                rd_data = DATA_W'(rd_state);
        end else begin
            case (rd_addr)
                ADDR_W'(RA_FIRST):  rd_data = DATA_W'(first_q);
                ADDR_W'(RA_LAST):   rd_data = DATA_W'(last_q);
                ADDR_W'(RA_STATUS): rd_data = status_q;
                default:            rd_data = '0;
            endcase
        end
    end

    // R8
    first_copies_last_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(RA_FIRST)) |=> (last_q == $past(wr_data[BW-1:0])));

endmodule

// File: tb/sim_flash_wp_manager.sv
module sim_flash_wp_manager;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = '0;
    logic        busy, done, cmd_err;

    int checks = 0;
    int fails  = 0;
    int busy_cnt = 0;

    typedef struct {
        bit    err;
        int    cycles;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_wp_manager #(.NUM_BLOCKS(NB)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .busy(busy), .done(done), .cmd_err(cmd_err)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected completion per done pulse
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cnt++;
            if (done) begin
                if (sb_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R14 unexpected done actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check({e.tag, " busy cycles"}, busy_cnt, e.cycles);
                    check({e.tag, " cmd_err"}, int'(cmd_err), int'(e.err));
                end
                busy_cnt = 0;
            end
        end
    end

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, int exp);
        int v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic do_cmd(logic [7:0] op, bit exp_err, int cycles, string tag, bit intrude);
        exp_t e;
        e.err = exp_err; e.cycles = cycles; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (intrude) begin
            cmd_valid = 1'b1; cmd_op = 8'h2A;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        wait (sb_q.size() == 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state, R2 encoding
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 cmd_err", int'(cmd_err), 0);
        rd_chk("R1 status", 8'h02, 2);
        rd_chk("R2 block0 locked", 8'h80, 2);
        rd_chk("R2 block11 locked", 8'h8B, 2);

        // R8 first write copies into last, last alone widens
        wr(8'h00, 16'h0002);
        rd_chk("R8 first", 8'h00, 2);
        rd_chk("R8 last copy", 8'h01, 2);
        wr(8'h01, 16'h0005);
        rd_chk("R8 last widened", 8'h01, 5);
        rd_chk("R8 first kept", 8'h00, 2);
        wr(8'h00, 16'h01F3);
        rd_chk("R8 first masked", 8'h00, 3);
        rd_chk("R8 last masked", 8'h01, 3);

        // R3 unlock 2..5, R10 timing, R9 status
        wr(8'h00, 16'd2); wr(8'h01, 16'd5);
        do_cmd(8'h23, 1'b0, 4, "R10 unlock range", 1'b0);
        rd_chk("R3 block1 untouched", 8'h81, 2);
        rd_chk("R3 block2 unlocked", 8'h82, 4);
        rd_chk("R3 block5 unlocked", 8'h85, 4);
        rd_chk("R3 block6 untouched", 8'h86, 2);
        rd_chk("R9 status unlocked", 8'h02, 4);

        // R6 lock-tight skips unlocked
        wr(8'h00, 16'd3); wr(8'h01, 16'd4);
        do_cmd(8'h2C, 1'b0, 2, "R6 tight on unlocked", 1'b0);
        rd_chk("R6 block3 stays unlocked", 8'h83, 4);
        rd_chk("R9 status unchanged by skips", 8'h02, 4);
        wr(8'h00, 16'd6); wr(8'h01, 16'd7);
        do_cmd(8'h2C, 1'b0, 2, "R6 tight on locked", 1'b0);
        rd_chk("R6 block6 tight", 8'h86, 1);
        rd_chk("R6 block7 tight", 8'h87, 1);
        rd_chk("R9 status tight", 8'h02, 1);

        // R4 lock range, R7 tight skipped
        wr(8'h00, 16'd5); wr(8'h01, 16'd8);
        do_cmd(8'h2A, 1'b0, 4, "R4 lock range", 1'b0);
        rd_chk("R4 block5 locked", 8'h85, 2);
        rd_chk("R7 block6 tight after lock", 8'h86, 1);
        rd_chk("R4 block8 locked", 8'h88, 2);
        rd_chk("R9 status last acted", 8'h02, 2);

        // R5 unlock all, R7
        do_cmd(8'h27, 1'b0, NB, "R5 unlock all", 1'b0);
        rd_chk("R5 block0 unlocked", 8'h80, 4);
        rd_chk("R5 block11 unlocked", 8'h8B, 4);
        rd_chk("R7 block7 tight after unlock all", 8'h87, 1);
        rd_chk("R9 status after all", 8'h02, 4);

        // R11 first > last
        wr(8'h00, 16'd7); wr(8'h01, 16'd3);
        do_cmd(8'h2A, 1'b0, 0, "R11 empty range", 1'b0);
        rd_chk("R11 block4 unchanged", 8'h84, 4);
        rd_chk("R11 status unchanged", 8'h02, 4);

        // R12 out-of-range stop
        wr(8'h00, 16'd10); wr(8'h01, 16'd14);
        do_cmd(8'h2A, 1'b1, 3, "R12 out of range", 1'b0);
        rd_chk("R12 block10 locked", 8'h8A, 2);
        rd_chk("R12 block11 locked", 8'h8B, 2);
        check("R12 err held", int'(cmd_err), 1);

        // R12 clear on next command
        wr(8'h00, 16'd0);
        do_cmd(8'h2A, 1'b0, 1, "R12 err cleared", 1'b0);
        rd_chk("R4 block0 locked", 8'h80, 2);

        // R14 strobe while busy ignored
        wr(8'h00, 16'd0); wr(8'h01, 16'd3);
        do_cmd(8'h23, 1'b0, 4, "R14 busy strobe", 1'b1);
        rd_chk("R14 block0 unlocked", 8'h80, 4);
        rd_chk("R14 block3 unlocked", 8'h83, 4);

        // R13 unknown opcode
        do_cmd(8'h55, 1'b1, 0, "R13 unknown op", 1'b0);
        rd_chk("R13 block1 unchanged", 8'h81, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule